// File: doc/BRIEF.md
# Queued Command Tag Tracker

This block sits on the host side of a disk link that supports native command queuing. It keeps track of which command tags are still pending in the drive. Each accepted queued command sets the bit for its tag in an outstanding bitmap. A completion notification carries a mask, and every pending tag named in that mask is retired. All tags retired by one notification are reported together, so they raise a single interrupt.

The block also controls when a command may be issued. An issue request is gated by the device busy input, by whether the tag is already pending, and by the rule that queued and non-queued work never overlap. A non-queued command finishes when the busy input has been seen high and then drops low.

Each accepted issue stores a 64-bit host buffer address for its tag. When the device names a tag in a DMA setup notice, that address is read back on the next cycle so the transfer can be programmed. All outputs are registered, so each reacts one clock after the inputs that cause it.

Top module: `ncq_tag_tracker`

## Requirements
- R1: While reset is held and on the first cycle after it, outstanding, done_mask, irq, nq_active and every pulse output are zero.
- R2: A queued issue (issue_queued=1) is accepted when dev_busy is low, its tag bit is clear and no non-queued command is active. On the next cycle the bit at position issue_tag of outstanding is set and issue_accept pulses for one cycle.
- R3: An issue request that is not accepted pulses issue_err for one cycle. It leaves outstanding unchanged. Causes include dev_busy high, a tag already pending, and a non-queued issue while outstanding is non-zero.
- R4: With cmpl_valid high, every outstanding bit whose cmpl_mask bit is set is cleared on the next cycle, and the same bits are ORed into done_mask.
- R5: Any cmpl_mask bit for a tag that is not outstanding has no effect on outstanding or done_mask, and it pulses proto_err for one cycle.
- R6: irq is high exactly while done_mask is non-zero. One notification that retires several tags produces one rising edge of irq. irq_ack clears done_mask, except for bits retired in the same cycle.
- R7: An accepted issue and a completion for different tags in the same cycle are both applied.
- R8: A non-queued issue (issue_queued=0) is accepted only when outstanding is all zero. After acceptance, nq_active stays high until dev_busy has been high and then goes low. In that cycle, nq_done pulses, nq_active falls and the command's tag bit is set in done_mask.
- R9: While nq_active is high, every issue request is rejected.
- R10: dma_valid with dma_tag gives dma_addr_valid on the next cycle, with dma_addr equal to the address given by the accepted issue of that tag.
- R11: A rejected issue does not overwrite the stored address of its tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_valid | input | 1 | Issue request this cycle |
| issue_queued | input | 1 | 1 = queued command, 0 = non-queued command |
| issue_tag | input | 5 | Tag of the issued command |
| issue_addr | input | 64 | Host buffer address for the tag |
| dev_busy | input | 1 | Device busy flag |
| cmpl_valid | input | 1 | Completion notification present |
| cmpl_mask | input | 32 | Tags reported complete |
| dma_valid | input | 1 | DMA setup notice present |
| dma_tag | input | 5 | Tag named in the DMA setup notice |
| irq_ack | input | 1 | Interrupt acknowledge; clears done_mask |
| issue_accept | output | 1 | Issue accepted (pulse) |
| issue_err | output | 1 | Issue rejected (pulse) |
| proto_err | output | 1 | Completion named a non-pending tag (pulse) |
| outstanding | output | 32 | Pending tag bitmap |
| nq_active | output | 1 | Non-queued command in flight |
| nq_done | output | 1 | Non-queued command finished (pulse) |
| done_mask | output | 32 | Retired tags awaiting acknowledge |
| irq | output | 1 | Interrupt request |
| dma_addr_valid | output | 1 | dma_addr holds a lookup result |
| dma_addr | output | 64 | Buffer address for the looked-up tag |

## Verification
Queued issues go to tags at both ends of the range and in the middle, so a decode error in the bitmap shows up as a wrong bit. Completions are tried with several patterns: a multi-tag mask to separate one interrupt per notification from one per tag, a mask naming idle tags to exercise the stray-bit path, and an acknowledge that coincides with a new retirement. An issue in the same cycle as the completion of another tag shows whether both updates are merged. The non-queued sequence tests gating on an empty bitmap, the busy-high-then-low completion, and rejection while it is in flight. DMA lookups after a rejected re-issue of the same tag distinguish a table that is written on every request from one that is written only on acceptance.

// File: rtl/ncq_pkg.sv
package ncq_pkg;
  typedef enum logic {
    CMD_NONQUEUED = 1'b0,
    CMD_QUEUED    = 1'b1
  } cmd_kind_e;
endpackage

// File: rtl/ncq_issue_gate.sv
module ncq_issue_gate #(
  parameter int NTAGS = 32,
  parameter int TAG_W = $clog2(NTAGS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  ncq_pkg::cmd_kind_e req_kind,
  input  logic [TAG_W-1:0] req_tag,
  input  logic             busy,
  input  logic [NTAGS-1:0] pending,
  output logic             fire_q,
  output logic             fire_nq,
  output logic             nq_fin,
  output logic [TAG_W-1:0] nq_fin_tag,
  output logic             accept_o,
  output logic             err_o,
  output logic             nq_active_o,
  output logic             nq_done_o
);
  logic             nq_seen_busy;
  logic [TAG_W-1:0] nq_tag_r;
  logic             tag_free;
  logic             map_empty;

  always_comb begin
    tag_free  = !pending[req_tag];
    map_empty = (pending == '0);
    fire_q    = req_valid && !busy && !nq_active_o &&
                (req_kind == ncq_pkg::CMD_QUEUED) && tag_free;
    fire_nq   = req_valid && !busy && !nq_active_o &&
                (req_kind == ncq_pkg::CMD_NONQUEUED) && map_empty;
    nq_fin    = nq_active_o && nq_seen_busy && !busy;
    nq_fin_tag = nq_tag_r;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      accept_o     <= 1'b0;
      err_o        <= 1'b0;
      nq_active_o  <= 1'b0;
      nq_seen_busy <= 1'b0;
      nq_done_o    <= 1'b0;
      nq_tag_r     <= '0;
    end else begin
      accept_o  <= fire_q || fire_nq;
      err_o     <= req_valid && !(fire_q || fire_nq);
      nq_done_o <= nq_fin;
      if (fire_nq) begin
        nq_active_o  <= 1'b1;
        nq_seen_busy <= 1'b0;
        nq_tag_r     <= req_tag;
      end else if (nq_fin) begin
        nq_active_o  <= 1'b0;
        nq_seen_busy <= 1'b0;
      end else if (nq_active_o && busy) begin
        nq_seen_busy <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/ncq_tag_bitmap.sv
module ncq_tag_bitmap #(
  parameter int NTAGS = 32,
  parameter int TAG_W = $clog2(NTAGS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             set_en,
  input  logic [TAG_W-1:0] set_tag,
  input  logic             clr_valid,
  input  logic [NTAGS-1:0] clr_mask,
  output logic [NTAGS-1:0] pending_o,
  output logic [NTAGS-1:0] retire_o,
  output logic             stray_o
);
  localparam logic [NTAGS-1:0] ONE = {{(NTAGS-1){1'b0}}, 1'b1};

  logic [NTAGS-1:0] set_vec;
  logic [NTAGS-1:0] nxt;

  always_comb begin
    set_vec  = set_en ? (ONE << set_tag) : '0;
    retire_o = clr_valid ? (clr_mask & pending_o) : '0;
    nxt      = (pending_o & ~retire_o) | set_vec;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pending_o <= '0;
      stray_o   <= 1'b0;
    end else begin
      pending_o <= nxt;
      stray_o   <= clr_valid && ((clr_mask & ~pending_o) != '0);
    end
  end
endmodule

// File: rtl/ncq_addr_table.sv
module ncq_addr_table #(
  parameter int DEPTH  = 32,
  parameter int AW     = $clog2(DEPTH),
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end

  always_ff @(posedge clk) begin
    if (rst) rvalid <= 1'b0;
    else     rvalid <= re;
  end
endmodule

// File: rtl/ncq_irq_agg.sv
module ncq_irq_agg #(
  parameter int NTAGS = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NTAGS-1:0] retire,
  input  logic             ack,
  output logic [NTAGS-1:0] done_o,
  output logic             irq_o
);
  logic [NTAGS-1:0] nxt;

  always_comb nxt = (ack ? '0 : done_o) | retire;

  always_ff @(posedge clk) begin
    if (rst) begin
      done_o <= '0;
      irq_o  <= 1'b0;
    end else begin
      done_o <= nxt;
      irq_o  <= (nxt != '0);
    end
  end
endmodule

// File: rtl/ncq_tag_tracker.sv
module ncq_tag_tracker #(
  parameter int NTAGS  = 32,
  parameter int ADDR_W = 64,
  parameter int TAG_W  = $clog2(NTAGS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              issue_valid,
  input  logic              issue_queued,
  input  logic [TAG_W-1:0]  issue_tag,
  input  logic [ADDR_W-1:0] issue_addr,
  input  logic              dev_busy,
  input  logic              cmpl_valid,
  input  logic [NTAGS-1:0]  cmpl_mask,
  input  logic              dma_valid,
  input  logic [TAG_W-1:0]  dma_tag,
  input  logic              irq_ack,
  output logic              issue_accept,
  output logic              issue_err,
  output logic              proto_err,
  output logic [NTAGS-1:0]  outstanding,
  output logic              nq_active,
  output logic              nq_done,
  output logic [NTAGS-1:0]  done_mask,
  output logic              irq,
  output logic              dma_addr_valid,
  output logic [ADDR_W-1:0] dma_addr
);
  localparam logic [NTAGS-1:0] ONE = {{(NTAGS-1){1'b0}}, 1'b1};

  ncq_pkg::cmd_kind_e kind;
  logic               fire_q, fire_nq, nq_fin;
  logic [TAG_W-1:0]   nq_fin_tag;
  logic [NTAGS-1:0]   retire_q;
  logic [NTAGS-1:0]   retire_all;

  assign kind = issue_queued ? ncq_pkg::CMD_QUEUED : ncq_pkg::CMD_NONQUEUED;

  ncq_issue_gate #(.NTAGS(NTAGS), .TAG_W(TAG_W)) u_gate (
    .clk(clk), .rst(rst),
    .req_valid(issue_valid), .req_kind(kind), .req_tag(issue_tag),
    .busy(dev_busy), .pending(outstanding),
    .fire_q(fire_q), .fire_nq(fire_nq),
    .nq_fin(nq_fin), .nq_fin_tag(nq_fin_tag),
    .accept_o(issue_accept), .err_o(issue_err),
    .nq_active_o(nq_active), .nq_done_o(nq_done)
  );

  ncq_tag_bitmap #(.NTAGS(NTAGS), .TAG_W(TAG_W)) u_map (
    .clk(clk), .rst(rst),
    .set_en(fire_q), .set_tag(issue_tag),
    .clr_valid(cmpl_valid), .clr_mask(cmpl_mask),
    .pending_o(outstanding), .retire_o(retire_q), .stray_o(proto_err)
  );

  ncq_addr_table #(.DEPTH(NTAGS), .AW(TAG_W), .DATA_W(ADDR_W)) u_tbl (
    .clk(clk), .rst(rst),
    .we(fire_q || fire_nq), .waddr(issue_tag), .wdata(issue_addr),
    .re(dma_valid), .raddr(dma_tag),
    .rdata(dma_addr), .rvalid(dma_addr_valid)
  );

  always_comb retire_all = retire_q | (nq_fin ? (ONE << nq_fin_tag) : '0);

  ncq_irq_agg #(.NTAGS(NTAGS)) u_irq (
    .clk(clk), .rst(rst),
    .retire(retire_all), .ack(irq_ack),
    .done_o(done_mask), .irq_o(irq)
  );
endmodule

// File: rtl/ncq_tag_tracker_chk.sv
module ncq_tag_tracker_chk #(
  parameter int NTAGS = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             issue_valid,
  input logic             dev_busy,
  input logic             cmpl_valid,
  input logic [NTAGS-1:0] cmpl_mask,
  input logic             dma_valid,
  input logic             irq_ack,
  input logic             issue_accept,
  input logic             issue_err,
  input logic [NTAGS-1:0] outstanding,
  input logic             nq_active,
  input logic             nq_done,
  input logic [NTAGS-1:0] done_mask,
  input logic             irq,
  input logic             dma_addr_valid
);
  assert_single_new_tag_R2: assert property (@(posedge clk) disable iff (rst)
    $countones(outstanding & ~$past(outstanding)) <= 1);

  assert_err_not_accept_R3: assert property (@(posedge clk) disable iff (rst)
    !(issue_err && issue_accept));

  assert_busy_keeps_map_R3: assert property (@(posedge clk) disable iff (rst)
    (issue_valid && dev_busy && !cmpl_valid) |=> $stable(outstanding));

  assert_mask_clears_R4: assert property (@(posedge clk) disable iff (rst)
    (cmpl_valid && !issue_valid) |=> ((outstanding & $past(cmpl_mask)) == '0));

  assert_irq_level_R6: assert property (@(posedge clk) disable iff (rst)
    irq == (done_mask != '0));

  assert_irq_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (irq && !irq_ack) |=> irq);

  assert_ack_clears_R6: assert property (@(posedge clk) disable iff (rst)
    (irq_ack && !cmpl_valid && !nq_active) |=> !irq);

  assert_nq_done_ends_R8: assert property (@(posedge clk) disable iff (rst)
    nq_done |-> !nq_active);

  assert_modes_exclusive_R9: assert property (@(posedge clk) disable iff (rst)
    nq_active |-> (outstanding == '0));

  assert_dma_latency_R10: assert property (@(posedge clk) disable iff (rst)
    dma_valid |=> dma_addr_valid);
endmodule

bind ncq_tag_tracker ncq_tag_tracker_chk #(.NTAGS(NTAGS)) u_chk (
  .clk(clk), .rst(rst), .issue_valid(issue_valid), .dev_busy(dev_busy),
  .cmpl_valid(cmpl_valid), .cmpl_mask(cmpl_mask), .dma_valid(dma_valid),
  .irq_ack(irq_ack), .issue_accept(issue_accept), .issue_err(issue_err),
  .outstanding(outstanding), .nq_active(nq_active), .nq_done(nq_done),
  .done_mask(done_mask), .irq(irq), .dma_addr_valid(dma_addr_valid)
);

// File: tb/ncq_tag_tracker_test.sv
module ncq_tag_tracker_test;
  localparam int NT = 32;
  localparam int TW = 5;
  localparam int AW = 64;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic iv = 0, iq = 0, busy = 0, cv = 0, dv = 0, ack = 0;
  logic [TW-1:0] itag = 0, dtag = 0;
  logic [AW-1:0] iaddr = 0;
  logic [NT-1:0] cmask = 0;
  logic acc, err, perr, nqa, nqd, irq, dav;
  logic [NT-1:0] outs, done;
  logic [AW-1:0] daddr;

  always #5 clk = ~clk;

  ncq_tag_tracker uut (
    .clk(clk), .rst(rst), .issue_valid(iv), .issue_queued(iq), .issue_tag(itag),
    .issue_addr(iaddr), .dev_busy(busy), .cmpl_valid(cv), .cmpl_mask(cmask),
    .dma_valid(dv), .dma_tag(dtag), .irq_ack(ack),
    .issue_accept(acc), .issue_err(err), .proto_err(perr), .outstanding(outs),
    .nq_active(nqa), .nq_done(nqd), .done_mask(done), .irq(irq),
    .dma_addr_valid(dav), .dma_addr(daddr)
  );

  typedef struct {
    int            due;
    string         req;
    logic [NT-1:0] outs, done;
    logic          acc, err, perr, nqa, nqd, irq, dav;
    logic [AW-1:0] daddr;
  } exp_t;

  exp_t q[$];
  int cyc = 0, total = 0, bad = 0, irq_rises = 0;
  logic irq_prev = 0;

  // reference state
  logic [NT-1:0] m_out = 0, m_done = 0;
  logic m_nq = 0, m_seen = 0;
  logic [TW-1:0] m_nqtag = 0;
  logic [AW-1:0] m_addr [NT];

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [NT-1:0] bit_of(input logic [TW-1:0] t);
    return {{(NT-1){1'b0}}, 1'b1} << t;
  endfunction

  task automatic step(input logic i_v, input logic i_q, input logic [TW-1:0] i_t,
                      input logic [AW-1:0] i_a, input logic b, input logic c_v,
                      input logic [NT-1:0] c_m, input logic d_v,
                      input logic [TW-1:0] d_t, input logic a, input string req);
    exp_t e;
    logic ok, fin;
    logic [NT-1:0] ret;
    @(negedge clk);
    iv = i_v; iq = i_q; itag = i_t; iaddr = i_a; busy = b;
    cv = c_v; cmask = c_m; dv = d_v; dtag = d_t; ack = a;
    fin = m_nq && m_seen && !b;
    ok  = i_v && !b && !m_nq && (i_q ? !m_out[i_t] : (m_out == 0));
    ret = c_v ? (c_m & m_out) : '0;
    e.due  = cyc + 1;
    e.req  = req;
    e.acc  = ok;
    e.err  = i_v && !ok;
    e.perr = c_v && ((c_m & ~m_out) != 0);
    e.outs = (m_out & ~ret) | ((ok && i_q) ? bit_of(i_t) : '0);
    e.done = (a ? '0 : m_done) | ret | (fin ? bit_of(m_nqtag) : '0);
    e.irq  = (e.done != 0);
    e.nqd  = fin;
    e.dav  = d_v;
    e.daddr = d_v ? m_addr[d_t] : daddr;
    if (ok && !i_q) begin m_nq = 1; m_seen = 0; m_nqtag = i_t; end
    else if (fin) begin m_nq = 0; m_seen = 0; end
    else if (m_nq && b) m_seen = 1;
    e.nqa = m_nq;
    if (ok) m_addr[i_t] = i_a;
    m_out = e.outs; m_done = e.done;
    q.push_back(e);
  endtask

  task automatic idle(input string req);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, req);
  endtask

  // monitor
  always @(negedge clk) begin
    if (!rst && irq && !irq_prev) irq_rises++;
    irq_prev = irq;
    if (q.size() > 0 && q[0].due == cyc) begin
      exp_t e;
      e = q.pop_front();
      total++;
      if (outs !== e.outs || done !== e.done || acc !== e.acc || err !== e.err ||
          perr !== e.perr || nqa !== e.nqa || nqd !== e.nqd || irq !== e.irq ||
          dav !== e.dav || (e.dav && daddr !== e.daddr)) begin
        bad++;
        $display("FAIL %s: got out=%h done=%h acc=%b err=%b perr=%b nqa=%b nqd=%b irq=%b dav=%b addr=%h | exp out=%h done=%h acc=%b err=%b perr=%b nqa=%b nqd=%b irq=%b dav=%b addr=%h",
          e.req, outs, done, acc, err, perr, nqa, nqd, irq, dav, daddr,
          e.outs, e.done, e.acc, e.err, e.perr, e.nqa, e.nqd, e.irq, e.dav, e.daddr);
      end
    end
  end

  task automatic check_bit(input logic got, input logic expv, input string req);
    total++;
    if (got !== expv) begin
      bad++;
      $display("FAIL %s: got %b expected %b", req, got, expv);
    end
  endtask

  initial begin
    #400000;
    bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int r0;
    repeat (3) @(negedge clk);
    // R1: outputs during reset
    check_bit(outs == 0 && done == 0 && !irq && !acc && !err && !perr && !nqa && !nqd,
              1'b1, "R1 in reset");
    rst = 0;
    idle("R1 after reset");
    // R2: queued issues across the tag range
    step(1, 1, 3,  64'hA3A3_0000_0000_0003, 0, 0, 0, 0, 0, 0, "R2 tag3");
    step(1, 1, 7,  64'h7777_0000_1111_0007, 0, 0, 0, 0, 0, 0, "R2 tag7");
    step(1, 1, 31, 64'hFFFF_0000_2222_001F, 0, 0, 0, 0, 0, 0, "R2 tag31");
    step(1, 1, 0,  64'h0000_1234_5678_0000, 0, 0, 0, 0, 0, 0, "R2 tag0");
    // R3 / R11: rejected issues
    step(1, 1, 3,  64'hDEAD_BEEF_DEAD_BEEF, 0, 0, 0, 0, 0, 0, "R3 tag pending");
    step(1, 1, 9,  64'h9, 1, 0, 0, 0, 0, 0, "R3 busy high");
    step(1, 0, 12, 64'hC, 0, 0, 0, 0, 0, 0, "R3 nonqueued with map busy");
    // R10 / R11: lookups
    step(0, 0, 0, 0, 0, 0, 0, 1, 3,  0, "R11 tag3 addr kept");
    step(0, 0, 0, 0, 0, 0, 0, 1, 7,  0, "R10 tag7");
    step(0, 0, 0, 0, 0, 0, 0, 1, 31, 0, "R10 tag31");
    // R4 / R6: one notification retiring three tags
    r0 = irq_rises;
    step(0, 0, 0, 0, 0, 1, bit_of(3) | bit_of(7) | bit_of(31), 0, 0, 0, "R4 multi retire");
    idle("R6 irq holds");
    idle("R6 irq holds 2");
    check_bit(irq_rises == r0 + 1, 1'b1, "R6 single irq edge");
    // R5: stray bits
    step(0, 0, 0, 0, 0, 1, bit_of(12) | bit_of(0), 0, 0, 0, "R5 stray plus real");
    step(0, 0, 0, 0, 0, 1, bit_of(20), 0, 0, 0, "R5 stray only");
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, "R6 ack");
    idle("R6 cleared");
    // R7: issue and completion together
    step(1, 1, 4, 64'h44, 0, 0, 0, 0, 0, 0, "R2 tag4");
    step(1, 1, 5, 64'h55, 0, 1, bit_of(4), 0, 0, 0, "R7 issue5 retire4");
    step(0, 0, 0, 0, 0, 1, bit_of(5), 0, 0, 1, "R6 ack with new retire");
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, "R6 ack again");
    // R8 / R9: non-queued path
    step(1, 1, 4, 64'h4444, 0, 0, 0, 0, 0, 0, "R2 tag4 again");
    step(1, 0, 2, 64'h2, 0, 0, 0, 0, 0, 0, "R8 nonqueued rejected map busy");
    step(0, 0, 0, 0, 0, 1, bit_of(4), 0, 0, 0, "R4 retire4");
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, "R6 ack");
    step(1, 0, 2, 64'h2222_2222_2222_2222, 0, 0, 0, 0, 0, 0, "R8 nonqueued accept");
    step(1, 1, 6, 64'h6, 0, 0, 0, 0, 0, 0, "R9 queued while nq");
    idle("R8 before busy");
    step(0, 0, 0, 0, 1, 0, 0, 0, 0, 0, "R8 busy high");
    step(1, 1, 6, 64'h6, 1, 0, 0, 0, 0, 0, "R9 busy with nq");
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R8 busy drops done");
    idle("R8 after done");
    step(0, 0, 0, 0, 0, 0, 0, 1, 2, 1, "R10 tag2 and ack");
    idle("R6 final clear");
    repeat (3) @(negedge clk);
    check_bit(q.size() == 0, 1'b1, "R1 scoreboard drained");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule